// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked host read and write an external asynchronous static RAM with a 19-bit word address and 8-bit words. The host issues one request at a time over a request/ready port and gets a one-cycle acknowledge when the access finishes. On the memory side the block drives four active-low controls and a tri-state data bus: chip select, write enable, output enable and a sleep control that parks the memory in a low-power, high-impedance state.

Every analog timing limit is given as a parameter in nanoseconds. The block rounds each limit up to whole clock cycles and counts them with a single shared down-counter. It also sequences the turnaround of the data bus and the sleep entry and wake-up.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, chip select, write enable and output enable are high, the sleep control is high (awake), the data bus is released, `ready_o` is high and `ack_o` is low.
- R2: A read holds chip select and output enable low with write enable and the sleep control high for RD_CYC cycles. RD_CYC is ceil(max(address access, output-enable access) / clock period), which is 3 at the defaults. The bus is sampled on the last of these edges and returned on `rdata_o` in the cycle `ack_o` is high. At the defaults `ack_o` rises 4 cycles after acceptance.
- R3: A write holds chip select and write enable low for WR_CYC cycles, where WR_CYC = max(ceil(write pulse / period), ceil(data setup / period)), which is 2 at the defaults. It drives the accepted write data on the bus for that whole pulse, puts the accepted address on `sram_addr_o` from the acceptance edge, and keeps output enable high throughout.
- R4: After each write pulse, write enable and chip select both return high for REC_CYC = ceil(recovery / period) cycles (1 at the defaults) before `ack_o`. Two writes issued back to back therefore see an inactive gap of REC_CYC + 1 cycles, and `ack_o` rises 4 cycles after a write is accepted.
- R5: The controller drives the data bus only while write enable is low, and it releases the bus on the edge that raises write enable.
- R6: Output enable never falls in the cycle after the controller drove the bus.
- R7: `ready_o` is high only in the idle state. A request is accepted on a rising edge with `req_i` and `ready_o` high. `ready_o` stays low from acceptance until the edge that raises `ack_o`. A request presented while `ready_o` is low is ignored: it produces no acknowledge and no memory access. `ack_o` is a single-cycle pulse.
- R8: With `sleep_req_i` high in the idle state, the sleep control is driven low on the next edge. `sleep_req_i` wins over a simultaneous request. While asleep, chip select, write enable and output enable stay high and `ready_o` stays low.
- R9: When `sleep_req_i` falls, the sleep control returns high on the next edge. `ready_o` then stays low for WAKE_CYC = ceil(wake-up access / period) cycles (3 at the defaults), so no access starts sooner. A read held pending from sleep acknowledges 8 cycles after the edge that wakes the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 19 | Word address |
| wdata_i | input | 8 | Write data |
| ready_o | output | 1 | Idle and able to accept a request |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read data, valid with ack_o |
| sleep_req_i | input | 1 | Request low-power sleep |
| sram_addr_o | output | 19 | Memory address |
| sram_cs_no | output | 1 | Chip select, active low |
| sram_we_no | output | 1 | Write enable, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_sl_no | output | 1 | Sleep control, low = asleep |
| sram_dq_io | inout | 8 | Bidirectional data bus |

## Verification
On every cycle, the assertions check the legal combinations of control pins: reads only with write enable high, and output enable high throughout a write. They also check that the bus is driven only during a write pulse, that output enable never falls right after the bus was driven, that sleep is entered only from idle and leaves all controls inactive, that recovery follows each pulse, and that acknowledge is a single pulse. Only the bench scenarios can show the exact cycle counts of reads, writes, recovery gaps and wake-up. The same holds for data integrity through a behavioural memory that returns garbage before its access time, and for a request being ignored while the controller is busy.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_RECOVER, ST_SLEEP, ST_WAKE
  } state_e;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // ceil(ns / period), never below one cycle
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/sram_delay_cnt.sv
module sram_delay_cnt #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == W'(1));

  // idle counter stays idle unless reloaded
  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/sram_dq_pad.sv
module sram_dq_pad #(
  parameter int unsigned DW = 8
) (
  input  logic          drv_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  inout  wire  [DW-1:0] dq_io
);
  assign dq_io   = drv_i ? wdata_i : {DW{1'bz}};
  assign rdata_o = dq_io;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW        = 19,
  parameter int unsigned DW        = 8,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_ACC_NS  = 25,
  parameter int unsigned T_OE_NS   = 9,
  parameter int unsigned T_WP_NS   = 20,
  parameter int unsigned T_DS_NS   = 15,
  parameter int unsigned T_REC_NS  = 5,
  parameter int unsigned T_WAKE_NS = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  input  logic          sleep_req_i,
  output logic [AW-1:0] sram_addr_o,
  output logic          sram_cs_no,
  output logic          sram_we_no,
  output logic          sram_oe_no,
  output logic          sram_sl_no,
  inout  wire  [DW-1:0] sram_dq_io
);
  localparam int unsigned RD_CYC   = ns2cyc(umax(T_ACC_NS, T_OE_NS), CLK_NS);
  localparam int unsigned WR_CYC   = umax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS));
  localparam int unsigned REC_CYC  = ns2cyc(T_REC_NS, CLK_NS);
  localparam int unsigned WAKE_CYC = ns2cyc(T_WAKE_NS, CLK_NS);
  localparam int unsigned CNT_MAX  = umax(umax(RD_CYC, WR_CYC), umax(REC_CYC, WAKE_CYC));
  localparam int unsigned CW       = $clog2(CNT_MAX + 1);

  state_e        state_q;
  logic          cs_n_q, we_n_q, oe_n_q, sl_n_q, drv_q, ack_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q, dq_rd;
  logic          cnt_load, cnt_last;
  logic [CW-1:0] cnt_val;

  sram_delay_cnt #(.W(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cnt_load),
    .val_i  (cnt_val),
    .last_o (cnt_last)
  );

  sram_dq_pad #(.DW(DW)) u_pad (
    .drv_i   (drv_q),
    .wdata_i (wdata_q),
    .rdata_o (dq_rd),
    .dq_io   (sram_dq_io)
  );

  always_comb begin
    cnt_load = 1'b0;
    cnt_val  = '0;
    case (state_q)
      ST_IDLE: if (!sleep_req_i && req_i) begin
        cnt_load = 1'b1;
        cnt_val  = we_i ? CW'(WR_CYC) : CW'(RD_CYC);
      end
      ST_WRITE: if (cnt_last) begin
        cnt_load = 1'b1;
        cnt_val  = CW'(REC_CYC);
      end
      ST_SLEEP: if (!sleep_req_i) begin
        cnt_load = 1'b1;
        cnt_val  = CW'(WAKE_CYC);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      sl_n_q  <= 1'b1;
      drv_q   <= 1'b0;
      ack_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      ack_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (sleep_req_i) begin
            sl_n_q  <= 1'b0;
            state_q <= ST_SLEEP;
          end else if (req_i) begin
            addr_q <= addr_i;
            cs_n_q <= 1'b0;
            if (we_i) begin
              wdata_q <= wdata_i;
              we_n_q  <= 1'b0;
              drv_q   <= 1'b1;
              state_q <= ST_WRITE;
            end else begin
              oe_n_q  <= 1'b0;
              state_q <= ST_READ;
            end
          end
        end
        ST_READ: if (cnt_last) begin
          rdata_q <= dq_rd;
          cs_n_q  <= 1'b1;
          oe_n_q  <= 1'b1;
          ack_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_WRITE: if (cnt_last) begin
          we_n_q  <= 1'b1;
          cs_n_q  <= 1'b1;
          drv_q   <= 1'b0;
          state_q <= ST_RECOVER;
        end
        ST_RECOVER: if (cnt_last) begin
          ack_q   <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_SLEEP: if (!sleep_req_i) begin
          sl_n_q  <= 1'b1;
          state_q <= ST_WAKE;
        end
        ST_WAKE: if (cnt_last) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign ack_o       = ack_q;
  assign rdata_o     = rdata_q;
  assign sram_addr_o = addr_q;
  assign sram_cs_no  = cs_n_q;
  assign sram_we_no  = we_n_q;
  assign sram_oe_no  = oe_n_q;
  assign sram_sl_no  = sl_n_q;

  p_rd_ctrl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_n_q |-> (!cs_n_q && we_n_q && sl_n_q));

  p_wr_no_oe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_q |-> (oe_n_q && !cs_n_q && sl_n_q));

  p_recover_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_n_q) |=> (we_n_q && cs_n_q));

  p_drive_in_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_q |-> !we_n_q);

  p_release_before_oe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_n_q) |-> !$past(drv_q));

  p_ack_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);

  p_busy_after_accept_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i && !sleep_req_i) |=> !ready_o);

  p_sleep_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sl_n_q |-> (cs_n_q && we_n_q && oe_n_q && !ready_o));

  p_sleep_from_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sl_n_q) |-> $past(state_q == ST_IDLE));

  p_wake_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sl_n_q) |=> !ready_o);
endmodule

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sleep_req = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready, ack;
  logic [7:0]  rdata;
  logic [18:0] s_addr;
  logic        cs_n, we_n, oe_n, sl_n;
  wire  [7:0]  dq;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .ack_o(ack), .rdata_o(rdata),
    .sleep_req_i(sleep_req), .sram_addr_o(s_addr), .sram_cs_no(cs_n),
    .sram_we_no(we_n), .sram_oe_no(oe_n), .sram_sl_no(sl_n), .sram_dq_io(dq)
  );

  // behavioural memory: 256 words keyed by low address bits
  logic [7:0]  mem [256];
  logic [7:0]  mdata = 8'hEE;
  logic [18:0] rd_a = '0;
  int          rd_age = 0;
  logic        pend = 1'b0;
  logic [7:0]  pd;
  logic [18:0] pa;
  int we_run = 0, last_we = 0, inact = 0, last_gap = 0, oe_bad = 0;
  int wake_age = 255, wake_bad = 0, ack_cnt = 0;
  wire m_rd = !cs_n && !oe_n && we_n && sl_n;
  assign dq = m_rd ? mdata : 8'hzz;

  always @(negedge clk) if (rst_n) begin
    if (m_rd) begin
      if (rd_age != 0 && rd_a == s_addr) rd_age++;
      else begin rd_age = 1; rd_a = s_addr; end
    end else rd_age = 0;
    mdata = (rd_age >= 3) ? mem[s_addr[7:0]] : 8'hEE;
    if (!cs_n && !we_n && sl_n) begin pend = 1'b1; pa = s_addr; pd = dq; end
    else if (pend) begin mem[pa[7:0]] = pd; pend = 1'b0; end
    if (!we_n) begin we_run++; if (!oe_n) oe_bad++; end
    else begin if (we_run != 0) last_we = we_run; we_run = 0; end
    if (we_n || cs_n) inact++;
    else begin if (inact != 0) last_gap = inact; inact = 0; end
    if (!sl_n) wake_age = 0; else if (wake_age < 255) wake_age++;
    if (!cs_n && wake_age < 3) wake_bad++;
    if (ack) ack_cnt++;
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic wait_ack(output int n);
    n = 1;
    while (!ack && n < 40) begin @(negedge clk); n++; end
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d, input bit b2b);
    int n;
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    chk(ready == 1'b0, "R7", "ready low after write accept", ready, 0);
    chk(s_addr == a, "R3", "write address", s_addr, a);
    chk(dq == d, "R3", "write data on bus", dq, d);
    wait_ack(n);
    chk(n == 4, "R4", "write ack latency", n, 4);
    chk(last_we == 2, "R3", "write pulse cycles", last_we, 2);
    if (b2b) chk(last_gap == 2, "R4", "gap between writes", last_gap, 2);
  endtask

  task automatic do_read(input logic [18:0] a, input logic [7:0] e);
    int n;
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    chk(ready == 1'b0, "R7", "ready low after read accept", ready, 0);
    chk(!cs_n && !oe_n && we_n && sl_n, "R2", "read control pins",
        {cs_n, oe_n, we_n, sl_n}, 4'b0011);
    wait_ack(n);
    chk(n == 4, "R2", "read ack latency", n, 4);
    chk(rdata == e, "R2", "read data", rdata, e);
  endtask

  task automatic busy_ignore();
    int n, base;
    while (!ready) @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 19'h40001; wdata = 8'h5A;
    @(negedge clk);
    base = ack_cnt;
    we = 1'b0; addr = 19'h00077;   // read request while busy, dropped before ready
    @(negedge clk);
    @(negedge clk);
    req = 1'b0;
    repeat (8) @(negedge clk);
    chk(ack_cnt - base == 1, "R7", "acks for ignored request", ack_cnt - base, 1);
    n = 0;
    do_read(19'h40001, 8'h5A);
    do_read(19'h00077, 8'h3C);
  endtask

  task automatic sleep_wake();
    int n;
    bit seen;
    while (!ready) @(negedge clk);
    sleep_req = 1'b1; req = 1'b1; we = 1'b0; addr = 19'h12345;
    @(negedge clk);
    chk(sl_n == 1'b0, "R8", "sleep pin low", sl_n, 0);
    chk(ready == 1'b0, "R8", "ready low asleep", ready, 0);
    repeat (3) begin
      @(negedge clk);
      chk(cs_n && we_n && oe_n, "R8", "controls idle asleep", {cs_n, we_n, oe_n}, 3'b111);
    end
    sleep_req = 1'b0;
    n = 0; seen = 1'b0;
    while (!ack && n < 40) begin
      @(negedge clk); n++;
      if (n == 1) chk(sl_n == 1'b1, "R9", "sleep pin high after release", sl_n, 1);
      if (n == 3) chk(ready == 1'b0, "R9", "ready low during wake", ready, 0);
      if (!cs_n) req = 1'b0;
    end
    chk(n == 8, "R9", "read latency from wake", n, 8);
    chk(rdata == 8'hA5, "R9", "read data after wake", rdata, 8'hA5);
  endtask

  bit done = 1'b0;
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(cs_n && we_n && oe_n && sl_n, "R1", "control pins in reset",
        {cs_n, we_n, oe_n, sl_n}, 4'hF);
    chk(ack == 1'b0, "R1", "ack in reset", ack, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1, "R1", "ready after reset", ready, 1);
    chk(cs_n && we_n && oe_n && sl_n, "R1", "controls after reset",
        {cs_n, we_n, oe_n, sl_n}, 4'hF);
    do_write(19'h12345, 8'hA5, 1'b0);
    do_write(19'h00077, 8'h3C, 1'b1);
    do_read(19'h12345, 8'hA5);
    do_read(19'h00077, 8'h3C);
    busy_ignore();
    sleep_wake();
    repeat (3) @(negedge clk);
    chk(oe_bad == 0, "R3", "output enable low during write", oe_bad, 0);
    chk(wake_bad == 0, "R9", "access too soon after wake", wake_bad, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule